// File: doc/BRIEF.md
# Backup Cell Selection and Isolation Controller

This controller decides which backup energy cell, if any, feeds the memory supply rail while main power is lost. The analog side is reduced to flags: main supply under the fail threshold, main supply under the switch-over level, secondary cell above 2.5 V, primary cell fitted, a battery-attach pulse, and two flags for the chip-enable level. The chip-enable level flags report either a level inside the 0.48 to 0.52 of supply band or a level above 0.54 of supply. The outputs are registered enables for each cell's connect switch, a charge enable for the rechargeable cell, and an isolation status.

While the supply is healthy, no cell is connected and the rechargeable cell is charged. Once the supply falls under the switch-over level, the rechargeable cell carries the load. If its voltage sags, the load moves to the primary cell after a one-cycle gap. To stop a battery draining when there is nothing to retain, the cells are kept isolated after a battery is attached. They are also isolated after a qualified shipping request: a mid-level chip-enable pulse of at least 700 ns held entirely between the fail-threshold and switch-over crossings of a power-down. Isolation lasts until the supply next returns.

Top module: `bkup_src_ctrl`

## Requirements
- R1: While `rst` is high, `iso_st` is 1 and `sec_en`, `pri_en` and `sec_chg_en` are 0.
- R2: One clock after `sup_fail` is sampled 0, `sec_chg_en` is 1 and both connect enables are 0.
- R3: One clock after `sup_fail`=1 with `sup_low`=0 (power-down window), both connect enables and `sec_chg_en` are 0.
- R4: One clock after `sup_low`=1 with `iso_st` clear and `sec_good`=1, `sec_en` is 1 and `pri_en` is 0.
- R5: If `sec_good` drops while the secondary is connected, both enables are 0 for exactly one clock, then `pri_en` is 1 when `pri_fitted`=1. The primary stays selected for the rest of that outage even if `sec_good` returns.
- R6: If `sec_good` is 0 when `sup_low` first rises, `pri_en` follows one clock later when `pri_fitted`=1; with `pri_fitted`=0 no cell is connected.
- R7: `sec_en` and `pri_en` are never both 1, and neither is 1 while `iso_st` is 1.
- R8: Reset or a `cell_attach` pulse sets `iso_st` and drops both enables on the next clock. `iso_st` clears one clock after `sup_fail` goes from 1 to 0.
- R9: A shipping request is valid when `ce_half` is held 1 for at least ceil(700 ns / clock period) consecutive clocks, the run starting after `ce_half` was seen 0 inside the window. When `sup_low` then rises, `iso_st` is set and no cell connects during that outage.
- R10: A run one clock shorter than the limit is ignored, and a drop of `ce_half` restarts the count: two shorter runs never add up.
- R11: `ce_high` seen at any clock inside the window cancels the request for that window.
- R12: A `ce_half` level already 1 when the window opens does not count until it has dropped once inside the window.
- R13: After a shipping isolation, the return of the supply clears `iso_st`, and the next outage connects a cell normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_fail | input | 1 | Main supply under fail threshold |
| sup_low | input | 1 | Main supply under switch-over level |
| sec_good | input | 1 | Rechargeable cell above 2.5 V |
| pri_fitted | input | 1 | Primary cell present |
| cell_attach | input | 1 | Pulse: battery newly attached |
| ce_half | input | 1 | Chip enable inside mid-supply band |
| ce_high | input | 1 | Chip enable above 0.54 of supply |
| sec_en | output | 1 | Connect rechargeable cell to memory rail |
| pri_en | output | 1 | Connect primary cell to memory rail |
| sec_chg_en | output | 1 | Charge enable for rechargeable cell |
| iso_st | output | 1 | Cells isolated from memory rail |

## Verification
Outages are driven with the secondary healthy, with it sagging mid-outage, and with it weak from the start with and without a primary fitted. These patterns separate direct selection, the break-before-make move and the sticky primary. The chip-enable patterns are a full-length pulse, a pulse one clock short, two split runs, a full pulse followed by an over-level spike, and a pulse already high at window entry. They show the counter threshold, the restart, the cancel and the arming rule. Attach pulses and power cycles after isolation show how isolation is entered and left.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SEC = 2'd1,
    SRC_GAP = 2'd2,
    SRC_PRI = 2'd3
  } src_state_t;

  function automatic int unsigned qual_cycles(input int unsigned period_ns,
                                              input int unsigned min_ns);
    return (min_ns + period_ns - 1) / period_ns;
  endfunction

endpackage

// File: rtl/bkup_iso_qual.sv
module bkup_iso_qual #(
  parameter int unsigned QUAL_CYCLES = 175
) (
  input  logic clk,
  input  logic rst,
  input  logic in_win,
  input  logic ce_half,
  input  logic ce_high,
  output logic qual_ok
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic          armed;
  logic          done;
  logic          cancel;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !in_win) begin
      armed  <= 1'b0;
      done   <= 1'b0;
      cancel <= 1'b0;
      cnt    <= '0;
    end else begin
      if (ce_high) cancel <= 1'b1;
      if (!ce_half) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && !done) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) done <= 1'b1;
      end
    end
  end

  assign qual_ok = done & ~cancel;

  // R9 / R12: qualification only completes on an armed mid-level run
  p_done_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ce_half) && $past(armed) && $past(in_win));

  // R11: an over-level sample inside the window blocks the request
  p_over_cancels_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(in_win) && $past(ce_high) && in_win) |-> !qual_ok);

endmodule

// File: rtl/bkup_src_sel.sv
module bkup_src_sel
  import bkup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_bkp,
  input  logic iso_d,
  input  logic sec_good,
  input  logic pri_fitted,
  output logic sec_en,
  output logic pri_en
);
  src_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!in_bkp || iso_d) begin
      st_d = SRC_OFF;
    end else begin
      unique case (st_q)
        SRC_OFF: st_d = sec_good ? SRC_SEC : SRC_PRI;
        SRC_SEC: st_d = sec_good ? SRC_SEC : SRC_GAP;
        SRC_GAP: st_d = SRC_PRI;
        SRC_PRI: st_d = SRC_PRI;
        default: st_d = SRC_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SRC_OFF;
      sec_en <= 1'b0;
      pri_en <= 1'b0;
    end else begin
      st_q   <= st_d;
      sec_en <= (st_d == SRC_SEC);
      pri_en <= (st_d == SRC_PRI) && pri_fitted;
    end
  end

  // R5: primary is never enabled on the clock right after the secondary
  p_break_before_make_r5: assert property (@(posedge clk) disable iff (rst)
    $past(sec_en) |-> !pri_en);

  // R5: primary selection persists while the outage lasts
  p_pri_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q == SRC_PRI) && $past(in_bkp) && in_bkp && !iso_d) |-> st_q == SRC_PRI);

endmodule

// File: rtl/bkup_src_ctrl.sv
module bkup_src_ctrl
  import bkup_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ISO_MIN_NS    = 700
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_fail,
  input  logic sup_low,
  input  logic sec_good,
  input  logic pri_fitted,
  input  logic cell_attach,
  input  logic ce_half,
  input  logic ce_high,
  output logic sec_en,
  output logic pri_en,
  output logic sec_chg_en,
  output logic iso_st
);
  localparam int unsigned QUAL_CYCLES = qual_cycles(CLK_PERIOD_NS, ISO_MIN_NS);

  logic sup_fail_q, sup_low_q;
  logic sup_ret, so_cross, in_win;
  logic qual_ok;
  logic iso_q, iso_d;

  assign in_win   = sup_fail & ~sup_low;
  assign sup_ret  = sup_fail_q & ~sup_fail;
  assign so_cross = sup_low & ~sup_low_q;
  assign iso_d    = cell_attach | (iso_q & ~sup_ret) | (so_cross & qual_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_fail_q <= 1'b0;
      sup_low_q  <= 1'b0;
      iso_q      <= 1'b1;
      sec_chg_en <= 1'b0;
    end else begin
      sup_fail_q <= sup_fail;
      sup_low_q  <= sup_low;
      iso_q      <= iso_d;
      sec_chg_en <= ~sup_fail;
    end
  end

  assign iso_st = iso_q;

  bkup_iso_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .in_win  (in_win),
    .ce_half (ce_half),
    .ce_high (ce_high),
    .qual_ok (qual_ok)
  );

  bkup_src_sel u_sel (
    .clk        (clk),
    .rst        (rst),
    .in_bkp     (sup_low),
    .iso_d      (iso_d),
    .sec_good   (sec_good),
    .pri_fitted (pri_fitted),
    .sec_en     (sec_en),
    .pri_en     (pri_en)
  );

  // R7: at most one cell feeds the rail
  p_one_source_r7: assert property (@(posedge clk) disable iff (rst)
    !(sec_en && pri_en));

  // R7: isolation keeps both cells off
  p_iso_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    iso_st |-> !sec_en && !pri_en);

  // R2 / R3: no cell connects above the switch-over level
  p_no_conn_above_so_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!sup_low) |-> !sec_en && !pri_en);

  // R2: charging only when no cell is feeding the rail
  p_charge_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    sec_chg_en |-> !sec_en && !pri_en);

  // R8: supply return clears isolation unless a new cell is attached
  p_iso_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(sup_fail, 2) && !$past(sup_fail) && !$past(cell_attach)) |-> !iso_st);

endmodule

// File: tb/bkup_src_ctrl_tb.sv
module bkup_src_ctrl_tb;
  localparam int unsigned PERIOD = 4;
  localparam int unsigned QUAL   = (700 + PERIOD - 1) / PERIOD;

  logic clk = 1'b0;
  logic rst, sup_fail, sup_low, sec_good, pri_fitted, cell_attach, ce_half, ce_high;
  logic sec_en, pri_en, sec_chg_en, iso_st;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bkup_src_ctrl #(.CLK_PERIOD_NS(PERIOD), .ISO_MIN_NS(700)) u_dut (
    .clk(clk), .rst(rst), .sup_fail(sup_fail), .sup_low(sup_low),
    .sec_good(sec_good), .pri_fitted(pri_fitted), .cell_attach(cell_attach),
    .ce_half(ce_half), .ce_high(ce_high), .sec_en(sec_en), .pri_en(pri_en),
    .sec_chg_en(sec_chg_en), .iso_st(iso_st)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {sec,pri,chg,iso} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {sec_en, pri_en, sec_chg_en, iso_st};
  endfunction

  task automatic go_window();
    sup_fail = 1'b1; sup_low = 1'b0; step(2);
  endtask

  task automatic go_valid();
    sup_fail = 1'b0; sup_low = 1'b0; ce_half = 1'b0; ce_high = 1'b0; step(1);
  endtask

  task automatic t_reset();
    rst = 1'b1; sup_fail = 0; sup_low = 0; sec_good = 1; pri_fitted = 1;
    cell_attach = 0; ce_half = 0; ce_high = 0;
    step(3);
    check("R1 reset state", outs(), 4'b0001);
    rst = 1'b0; step(1);
    check("R2 charge after reset", outs(), 4'b0011);
  endtask

  task automatic t_attach_iso();
    go_window(); sup_low = 1'b1; step(2);
    check("R8 isolated outage after reset", outs(), 4'b0001);
    go_valid();
    check("R8 supply return clears", outs(), 4'b0010);
  endtask

  task automatic t_secondary();
    go_window();
    check("R3 window no conn no charge", outs(), 4'b0000);
    sup_low = 1'b1; step(1);
    check("R4 secondary connects", outs(), 4'b1000);
  endtask

  task automatic t_move_primary();
    sec_good = 1'b0; step(1);
    check("R5 break gap", outs(), 4'b0000);
    step(1);
    check("R5 primary after gap", outs(), 4'b0100);
    sec_good = 1'b1; step(2);
    check("R5 primary sticky", outs(), 4'b0100);
    go_valid();
    check("R2 valid disconnects and charges", outs(), 4'b0010);
  endtask

  task automatic t_weak_start();
    sec_good = 1'b0; go_window(); sup_low = 1'b1; step(1);
    check("R6 direct primary", outs(), 4'b0100);
    go_valid();
    pri_fitted = 1'b0; go_window(); sup_low = 1'b1; step(1);
    check("R6 no primary fitted", outs(), 4'b0000);
    go_valid(); sec_good = 1'b1; pri_fitted = 1'b1;
  endtask

  task automatic t_valid_request();
    go_window();
    ce_half = 1'b1; step(QUAL);
    ce_half = 1'b0; step(1);
    sup_low = 1'b1; step(1);
    check("R9 request isolates", outs(), 4'b0001);
    step(3);
    check("R9 stays isolated", outs(), 4'b0001);
    go_valid();
    check("R13 return clears", outs(), 4'b0010);
    go_window(); sup_low = 1'b1; step(1);
    check("R13 next outage connects", outs(), 4'b1000);
    go_valid();
  endtask

  task automatic t_short_pulse();
    go_window();
    ce_half = 1'b1; step(QUAL - 1);
    ce_half = 1'b0; step(1);
    sup_low = 1'b1; step(1);
    check("R10 short pulse ignored", outs(), 4'b1000);
    go_valid();
    go_window();
    ce_half = 1'b1; step(100); ce_half = 1'b0; step(1);
    ce_half = 1'b1; step(100); ce_half = 1'b0; step(1);
    sup_low = 1'b1; step(1);
    check("R10 split runs ignored", outs(), 4'b1000);
    go_valid();
  endtask

  task automatic t_over_level();
    go_window();
    ce_half = 1'b1; step(QUAL);
    ce_half = 1'b0; ce_high = 1'b1; step(1);
    ce_high = 1'b0; step(1);
    sup_low = 1'b1; step(1);
    check("R11 over-level cancels", outs(), 4'b1000);
    go_valid();
  endtask

  task automatic t_early_pulse();
    ce_half = 1'b1; step(1);
    sup_fail = 1'b1; step(QUAL + 5);
    ce_half = 1'b0; step(1);
    sup_low = 1'b1; step(1);
    check("R12 pre-window pulse ignored", outs(), 4'b1000);
  endtask

  task automatic t_attach_backup();
    cell_attach = 1'b1; step(1); cell_attach = 1'b0;
    check("R8 attach isolates", outs(), 4'b0001);
    step(2);
    check("R7 isolated no source", outs(), 4'b0001);
    go_valid();
    check("R8 attach cleared by return", outs(), 4'b0010);
  endtask

  initial begin
    t_reset();
    t_attach_iso();
    t_secondary();
    t_move_primary();
    t_weak_start();
    t_valid_request();
    t_short_pulse();
    t_over_level();
    t_early_pulse();
    t_attach_backup();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule